// File: doc/BRIEF.md
# Paired-Register 64-Bit Left Shifter

This execution unit holds a 32-bit accumulator, a 32-bit product register, a small status word and a repeat counter. When an instruction word is issued whose upper twelve bits carry the shift opcode, the unit joins the accumulator (upper half) and the product register (lower half) into one 64-bit operand. It shifts that operand left by an immediate count of 1 to 16 and writes the halves back. On the same clock edge it updates the negative, zero and carry bits of the status word. Every other status bit is left as it was.

The shift cannot be repeated. If a repeat count is pending when the shift executes, the count is dropped and the counter is cleared. A plain load port stands in for the move instructions that would surround the shift, so that operands, status and the repeat count can be placed in the unit. Any word that does not match the opcode leaves all state alone and raises a one-cycle unsupported-instruction pulse.

Top module: `lsl64_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the product register, the status word, the repeat counter and the unsupported pulse.
- R2: A word with `insn[15:4] == 12'h56A`, issued with `issue_valid` high, shifts the 64-bit value {accumulator, product} left by `insn[3:0] + 1` places (so 4'h0 gives 1 and 4'hF gives 16). Vacated low bits are filled with zeros. The upper 32 result bits go to the accumulator and the lower 32 bits go to the product register.
- R3: After a shift, status bit 0 (carry) holds the last bit shifted out, which is bit (64 - count) of the original 64-bit value.
- R4: After a shift, status bit 2 (negative) equals bit 31 of the new accumulator.
- R5: After a shift, status bit 1 (zero) is 1 exactly when all 64 result bits are zero.
- R6: A shift leaves every status bit other than bits 0, 1 and 2 unchanged.
- R7: A shift sets the repeat counter to zero and executes once. This holds even when a repeat count is written in the same cycle.
- R8: A word issued with a non-matching upper twelve bits, while the load port is idle, leaves the accumulator, the product register, the status word and the repeat counter unchanged. It also drives `bad_insn` high for exactly the one cycle that follows the accepting edge.
- R9: The load port writes the accumulator, the product register and the status word only in cycles in which no shift executes. When a load and a shift share a cycle, the shift operates on the old values and its result is kept.
- R10: `issue_ready` is always high, and all updates appear on the clock edge at which `issue_valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word presented |
| issue_ready | output | 1 | Unit accepts a word (always high) |
| insn | input | 16 | Instruction word |
| ld_en | input | 1 | Load port write enable |
| ld_acc | input | 32 | Value for the accumulator |
| ld_prod | input | 32 | Value for the product register |
| ld_stat | input | 8 | Value for the status word |
| rpt_set | input | 1 | Write the repeat counter |
| rpt_val | input | 16 | Repeat count to write |
| acc_q | output | 32 | Accumulator |
| prod_q | output | 32 | Product register |
| stat_q | output | 8 | Status word (bit 2 negative, bit 1 zero, bit 0 carry) |
| rpt_q | output | 16 | Repeat counter |
| bad_insn | output | 1 | One-cycle pulse after a non-matching word |

## Verification
The hardest case to reach from the ports is a carry of 1 together with a zero result. That needs an operand whose only set bit sits exactly at position 64 minus the count, so that bit is the last one to leave. The bench builds that operand for every count from 1 to 16, along with its neighbour one place lower, which gives a set negative bit. The second hard case is a repeat count written in the very cycle the shift issues. The bench drives both strobes together and then reads the counter back.

// File: rtl/lsl64_pkg.sv
package lsl64_pkg;

    localparam int INSN_W  = 16;
    localparam int SHF_W   = 4;
    localparam int OPC_W   = INSN_W - SHF_W;
    localparam logic [OPC_W-1:0] OPC_LSL = 12'h56A;

    typedef struct packed {
        logic             hit;
        logic             miss;
        logic [SHF_W-1:0] amt_m1;
    } dec_t;

    function automatic logic [OPC_W-1:0] opc_field(input logic [INSN_W-1:0] w);
        return w[INSN_W-1:SHF_W];
    endfunction

    function automatic logic [SHF_W-1:0] amt_field(input logic [INSN_W-1:0] w);
        return w[SHF_W-1:0];
    endfunction

endpackage

// File: rtl/lsl64_decode.sv
module lsl64_decode
    import lsl64_pkg::*;
(
    input  logic              valid,
    input  logic [INSN_W-1:0] word,
    output dec_t              dec
);
    always_comb begin
        dec.hit    = valid && (opc_field(word) == OPC_LSL);
        dec.miss   = valid && (opc_field(word) != OPC_LSL);
        dec.amt_m1 = amt_field(word);
    end
endmodule

// File: rtl/lsl64_shifter.sv
module lsl64_shifter #(
    parameter int W    = 64,
    parameter int SH_W = 4
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt_m1,
    output logic [W-1:0]    dout,
    output logic            cout
);
    // stage vectors carry one extra top bit that catches the last bit out
    logic [W:0] stg [SH_W+2];

    assign stg[0] = {1'b0, din};
    assign stg[1] = {stg[0][W-1:0], 1'b0};

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+2] = amt_m1[k] ? {stg[k+1][W-SH:0], {SH{1'b0}}} : stg[k+1];
    end

    assign dout = stg[SH_W+1][W-1:0];
    assign cout = stg[SH_W+1][W];
endmodule

// File: rtl/lsl64_flags.sv
module lsl64_flags #(
    parameter int W     = 64,
    parameter int ST_W  = 8,
    parameter int C_POS = 0,
    parameter int Z_POS = 1,
    parameter int N_POS = 2
) (
    input  logic [W-1:0]    res,
    input  logic            cout,
    input  logic [ST_W-1:0] st_in,
    output logic [ST_W-1:0] st_out
);
    always_comb begin
        st_out        = st_in;
        st_out[C_POS] = cout;
        st_out[Z_POS] = (res == '0);
        st_out[N_POS] = res[W-1];
    end
endmodule

// File: rtl/lsl64_unit.sv
module lsl64_unit
    import lsl64_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int ST_W   = 8,
    parameter int RC_W   = 16,
    parameter int C_POS  = 0,
    parameter int Z_POS  = 1,
    parameter int N_POS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [INSN_W-1:0] insn,
    input  logic              ld_en,
    input  logic [HALF_W-1:0] ld_acc,
    input  logic [HALF_W-1:0] ld_prod,
    input  logic [ST_W-1:0]   ld_stat,
    input  logic              rpt_set,
    input  logic [RC_W-1:0]   rpt_val,
    output logic [HALF_W-1:0] acc_q,
    output logic [HALF_W-1:0] prod_q,
    output logic [ST_W-1:0]   stat_q,
    output logic [RC_W-1:0]   rpt_q,
    output logic              bad_insn
);
    localparam int FULL_W = 2 * HALF_W;
    localparam logic [ST_W-1:0] FLAG_MASK =
        ST_W'((1 << C_POS) | (1 << Z_POS) | (1 << N_POS));

    dec_t              dec;
    logic [FULL_W-1:0] res;
    logic              cout;
    logic [ST_W-1:0]   st_next;

    assign issue_ready = 1'b1;

    lsl64_decode u_dec (
        .valid (issue_valid),
        .word  (insn),
        .dec   (dec)
    );

    lsl64_shifter #(.W(FULL_W), .SH_W(SHF_W)) u_shf (
        .din    ({acc_q, prod_q}),
        .amt_m1 (dec.amt_m1),
        .dout   (res),
        .cout   (cout)
    );

    lsl64_flags #(.W(FULL_W), .ST_W(ST_W), .C_POS(C_POS), .Z_POS(Z_POS), .N_POS(N_POS)) u_flg (
        .res    (res),
        .cout   (cout),
        .st_in  (stat_q),
        .st_out (st_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            prod_q   <= '0;
            stat_q   <= '0;
            rpt_q    <= '0;
            bad_insn <= 1'b0;
        end else begin
            bad_insn <= dec.miss;
            if (dec.hit) begin
                acc_q  <= res[FULL_W-1:HALF_W];
                prod_q <= res[HALF_W-1:0];
                stat_q <= st_next;
                rpt_q  <= '0;
            end else begin
                if (ld_en) begin
                    acc_q  <= ld_acc;
                    prod_q <= ld_prod;
                    stat_q <= ld_stat;
                end
                if (rpt_set) rpt_q <= rpt_val;
            end
        end
    end

    // R7
    rpt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> (rpt_q == '0));

    // R4
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> (stat_q[N_POS] == acc_q[HALF_W-1]));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> (stat_q[Z_POS] == ((acc_q == '0) && (prod_q == '0))));

    // R2
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> (prod_q[0] == 1'b0));

    // R6
    other_bits_chk: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> ((stat_q & ~FLAG_MASK) == ($past(stat_q) & ~FLAG_MASK)));

    // R8
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.miss && !ld_en && !rpt_set) |=>
            ($stable(acc_q) && $stable(prod_q) && $stable(stat_q) && $stable(rpt_q) && bad_insn));

    // R8
    miss_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> !bad_insn);

    // R10
    ready_chk: assert property (@(posedge clk) disable iff (rst) issue_ready);
endmodule

// File: tb/tb_lsl64_unit.sv
`timescale 1ns/1ps
module tb_lsl64_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic        issue_ready;
    logic [15:0] insn;
    logic        ld_en;
    logic [31:0] ld_acc, ld_prod;
    logic [7:0]  ld_stat;
    logic        rpt_set;
    logic [15:0] rpt_val;
    logic [31:0] acc_q, prod_q;
    logic [7:0]  stat_q;
    logic [15:0] rpt_q;
    logic        bad_insn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lsl64_unit dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .insn(insn), .ld_en(ld_en), .ld_acc(ld_acc), .ld_prod(ld_prod), .ld_stat(ld_stat),
        .rpt_set(rpt_set), .rpt_val(rpt_val), .acc_q(acc_q), .prod_q(prod_q),
        .stat_q(stat_q), .rpt_q(rpt_q), .bad_insn(bad_insn)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        issue_valid = 0; insn = 16'h0; ld_en = 0; rpt_set = 0;
    endtask

    // one clock: inputs already driven at negedge, sample at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic load(input logic [63:0] v, input logic [7:0] st, input logic [15:0] rc);
        ld_en = 1; ld_acc = v[63:32]; ld_prod = v[31:0]; ld_stat = st;
        rpt_set = 1; rpt_val = rc;
        step();
    endtask

    function automatic logic [15:0] shw(input int s);
        return {12'h56A, 4'(s - 1)};
    endfunction

    task automatic run_shift(input logic [63:0] v, input int s, input logic [7:0] st, input bit same_rpt);
        logic [63:0] r;
        logic        c;
        logic [7:0]  est;
        load(v, st, 16'h0005 + 16'(s));
        r = v << s;
        c = v[64 - s];
        est = (st & 8'hF8) | {5'b0, r[63], (r == 64'h0), c};
        issue_valid = 1; insn = shw(s);
        if (same_rpt) begin rpt_set = 1; rpt_val = 16'hABCD; end
        step();
        check("R2 result", {acc_q, prod_q}, r);
        check("R3 carry", 64'(stat_q[0]), 64'(c));
        check("R4 negative", 64'(stat_q[2]), 64'(r[63]));
        check("R5 zero", 64'(stat_q[1]), 64'(r == 64'h0));
        check("R6 other status", 64'(stat_q), 64'(est));
        check("R7 repeat cleared", 64'(rpt_q), 64'h0);
        check("R8 no bad pulse on match", 64'(bad_insn), 64'h0);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(); ld_acc = 0; ld_prod = 0; ld_stat = 0; rpt_val = 0;
        rst = 1;
        ld_en = 1; ld_acc = 32'hFFFF_FFFF; ld_prod = 32'h1234_5678; ld_stat = 8'hFF;
        rpt_set = 1; rpt_val = 16'h7;
        @(negedge clk); @(negedge clk);
        check("R1 acc", 64'(acc_q), 0);
        check("R1 prod", 64'(prod_q), 0);
        check("R1 stat", 64'(stat_q), 0);
        check("R1 rpt", 64'(rpt_q), 0);
        check("R1 bad", 64'(bad_insn), 0);
        check("R10 ready", 64'(issue_ready), 1);
        rst = 0; idle();
        @(negedge clk);

        // sweep every count against a range of operand patterns
        for (int s = 1; s <= 16; s++) begin
            logic [63:0] pats [8];
            pats[0] = 64'h0;
            pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
            pats[2] = 64'h1 << (64 - s);
            pats[3] = 64'h1 << (63 - s);
            pats[4] = 64'h9E37_79B9_7F4A_7C15 * 64'(s);
            pats[5] = 64'h8000_0000_0000_0001;
            pats[6] = {32'h0, 32'hDEAD_BEEF} ^ (64'(s) << 40);
            pats[7] = ~(64'hC2B2_AE3D_27D4_EB4F * 64'(s + 3));
            for (int i = 0; i < 8; i++)
                run_shift(pats[i], s, 8'(8'h5A + 8'(s * 13 + i * 7)), (i % 3) == 1);
        end

        // R9: load in the same cycle as a shift loses
        load(64'h0000_0001_8000_0000, 8'h00, 16'h3);
        issue_valid = 1; insn = shw(1);
        ld_en = 1; ld_acc = 32'h1111_1111; ld_prod = 32'h2222_2222; ld_stat = 8'hF0;
        step();
        check("R9 shift wins over load", {acc_q, prod_q}, 64'h0000_0003_0000_0000);
        check("R9 status from shift", 64'(stat_q), 64'h00);

        // R9: load with a bad word still writes
        issue_valid = 1; insn = 16'h0000;
        ld_en = 1; ld_acc = 32'hCAFE_0001; ld_prod = 32'h0BAD_0002; ld_stat = 8'h81;
        step();
        check("R9 load beside bad word", {acc_q, prod_q}, 64'hCAFE_0001_0BAD_0002);
        check("R9 load status", 64'(stat_q), 64'h81);

        // R8: every non-matching prefix
        load(64'h0123_4567_89AB_CDEF, 8'hA5, 16'h0042);
        for (int pfx = 0; pfx < 4096; pfx++) begin
            if (pfx != 12'h56A) begin
                issue_valid = 1; insn = {12'(pfx), 4'(pfx * 7)};
                step();
                if (bad_insn !== 1'b1 || {acc_q, prod_q} !== 64'h0123_4567_89AB_CDEF ||
                    stat_q !== 8'hA5 || rpt_q !== 16'h0042)
                    check("R8 miss holds state", {31'(bad_insn), acc_q, 8'(stat_q), 16'(rpt_q)},
                          {31'h1, 32'h0123_4567, 8'hA5, 16'h0042});
                else checks++;
                @(negedge clk);
                check("R8 pulse lasts one cycle", 64'(bad_insn), 0);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule